// File: doc/BRIEF.md
# Register Zip/Unzip Transfer Sequencer

This block takes one 32-bit register-interleave move instruction and turns it into a stream of single register transfers, one per clock cycle. In zip form it merges one, two or three source register vectors into a single interleaved destination vector. In unzip form it takes one interleaved vector apart again and spreads it over several destination vectors. Each transfer cycle gives a source register index, a destination register index and a write strobe. A register file beside the block carries out the actual moves.

The interleave factor is not a separate field. It comes from which register fields of the instruction are zero. The vector length VL and the subvector size SUBVL (1 to 4) arrive alongside the instruction. When SUBVL is above 1, a whole subvector group is one contiguous unit: one strobe moves the whole group, and every index advances by SUBVL. Element-width conversion and saturation belong to the datapath and are not handled here.

Top module: `regzip_sequencer`

## Requirements
- R1: An instruction is legal only when instr[31:26] equals 19 and instr[5:1] equals 10 (zip) or 11 (unzip). The register fields sit at instr[25:21] (T), instr[20:16] (C), instr[15:11] (B, written S for unzip) and instr[10:6] (A). Indices are IDX_W = 7 bits wide and wrap modulo 128.
- R2: When an illegal instruction is started, no strobe is issued and `done` pulses in the next cycle. `illegal` rises at the same time and stays high until the next start accepted while idle, which clears it if that instruction is legal.
- R3: Zip with B = 0 is a plain copy. Transfer i moves register C + i·S to T + i·S, where S is SUBVL.
- R4: Zip with B ≠ 0 and A = 0 is two-way. For each element i it moves B + i·S to T + 2i·S, then C + i·S to T + (2i+1)·S.
- R5: Zip with both B and A nonzero is three-way. For each element i it issues B, then C, then A, to T + 3i·S, T + (3i+1)·S and T + (3i+2)·S, one per cycle.
- R6: When B = 0, the A field has no effect and the operation is one-way.
- R7: The input `subvl_m1` encodes SUBVL − 1, so 0 to 3 stands for 1 to 4. Every index step is scaled by SUBVL, and one strobe moves one whole group.
- R8: Unzip is the inverse of zip. Its source is the interleaved vector at C, step by step from C + (i·W + k)·S. The targets are, in slot order, S-field, T and A, each at base + i·S. The way count W comes from B/A as in R3 to R5, and one-way unzip writes to T.
- R9: The first strobe comes in the cycle after start is sampled. Strobes then follow in back-to-back cycles, VL·W of them. `done` pulses for one cycle in the cycle after the last strobe. VL = 0 gives `done` in the cycle after start, with no strobe.
- R10: A start while a run is in progress is ignored. The record bit instr[0] has no effect.
- R11: After reset, `wr_en`, `done` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin decoding `instr`; taken only while idle |
| instr | input | 32 | Zip/unzip instruction word |
| vl | input | VL_W | Vector length in elements |
| subvl_m1 | input | 2 | Subvector size minus one |
| wr_en | output | 1 | Transfer strobe |
| src_idx | output | IDX_W | Source register index of this transfer |
| dst_idx | output | IDX_W | Destination register index of this transfer |
| done | output | 1 | One-cycle pulse when the operation ends |
| illegal | output | 1 | Last accepted instruction failed decode |

## Verification
A scoreboard compares every strobe, in order, with indices computed from the field rules.

The bench covers each way count in both directions. A wrong way-count decode or a swapped slot order shows up as a mismatched index on an early strobe. A SUBVL of 4 with a long vector pushes the destination past index 127; a missing wrap or an unscaled step gives wrong indices there. Further cases are:
- A nonzero A field with a zero B field. A design that trusts A alone would emit extra transfers.
- VL = 0 and illegal opcodes. A design that strobes anyway, or is late with `done`, gets caught.
- A second start injected mid-run, and a set record bit. Either would show up as corrupted or restarted index streams.

// File: rtl/regzip_pkg.sv
// Shared constants and the decoded-command record for the zip/unzip sequencer.
// Assumes the big-endian field layout: primary opcode in the top six bits.
package regzip_pkg;
    localparam logic [5:0] PRIMARY_OP = 6'd19;
    localparam logic [4:0] XO_ZIP     = 5'd10;
    localparam logic [4:0] XO_UNZIP   = 5'd11;
    localparam int         NUM_SLOTS  = 3;

    typedef struct packed {
        logic       legal;     // opcode and extended opcode recognised
        logic       unzip;     // 1 = split, 0 = merge
        logic [1:0] ways;      // interleave factor 1..3
        logic [4:0] lin_base;  // base of the interleaved vector
        logic [4:0] slot0;     // first per-element slot (B / S field)
        logic [4:0] slot1;     // middle slot (C for zip, T for unzip)
        logic [4:0] slot2;     // last slot (A field)
    } regzip_cmd_t;
endpackage

// File: rtl/regzip_decode.sv
// Field decoder: splits the instruction into register fields, checks the
// opcodes and derives the interleave factor from the zero-ness of B and A.
// Purely combinational; assumes instr is stable while start is high.
module regzip_decode
    import regzip_pkg::*;
(
    input  logic [31:0]  instr,
    output regzip_cmd_t  cmd
);
    logic [5:0] f_op;
    logic [4:0] f_t, f_c, f_b, f_a, f_xo;
    logic       unused_rcbit;

    assign f_op         = instr[31:26];
    assign f_t          = instr[25:21];
    assign f_c          = instr[20:16];
    assign f_b          = instr[15:11];
    assign f_a          = instr[10:6];
    assign f_xo         = instr[5:1];
    assign unused_rcbit = instr[0];

    // Build the command record from the raw fields.
    always_comb begin
        cmd.legal = (f_op == PRIMARY_OP) && ((f_xo == XO_ZIP) || (f_xo == XO_UNZIP));
        cmd.unzip = (f_xo == XO_UNZIP);
        if (f_b == 5'd0)
            cmd.ways = 2'd1;
        else if (f_a == 5'd0)
            cmd.ways = 2'd2;
        else
            cmd.ways = 2'd3;
        cmd.lin_base = cmd.unzip ? f_c : f_t;
        cmd.slot0    = f_b;
        cmd.slot1    = cmd.unzip ? f_t : f_c;
        cmd.slot2    = f_a;
    end
endmodule

// File: rtl/regzip_stepper.sv
// Transfer stepper: on an accepted start it loads the base pointers and then
// issues one transfer per cycle. The linear pointer walks the interleaved
// vector; one pointer per slot walks the separate vectors. All arithmetic is
// incremental (no multipliers) and wraps modulo 2**IDX_W.
module regzip_stepper
    import regzip_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int VL_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  regzip_cmd_t       cmd,
    input  logic [VL_W-1:0]   vl,
    input  logic [1:0]        subvl_m1,
    output logic              wr_en,
    output logic [IDX_W-1:0]  src_idx,
    output logic [IDX_W-1:0]  dst_idx,
    output logic              done,
    output logic              illegal,
    output logic              run_unzip,
    output logic [2:0]        run_step
);
    logic                  run_q, done_q, illegal_q, unzip_q;
    logic [1:0]            way_q, ways_q, cur_slot;
    logic [VL_W-1:0]       elem_q, vlast_q;
    logic [IDX_W-1:0]      lin_q, slot_ptr;
    logic [2:0]            step_q;
    logic [NUM_SLOTS-1:0][IDX_W-1:0] ptr_all;
    logic [NUM_SLOTS-1:0][4:0]       slot_base;
    logic                  accept, go, last_way, last_elem, elem_adv;

    assign accept    = start && !run_q;
    assign go        = accept && cmd.legal && (vl != '0);
    assign last_way  = (way_q == ways_q - 2'd1);
    assign last_elem = (elem_q == vlast_q);
    assign elem_adv  = run_q && last_way;
    assign slot_base = {cmd.slot2, cmd.slot1, cmd.slot0};

    // Control: run flag, way/element counters, linear pointer, flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            unzip_q   <= 1'b0;
            way_q     <= 2'd0;
            ways_q    <= 2'd1;
            elem_q    <= '0;
            vlast_q   <= '0;
            lin_q     <= '0;
            step_q    <= 3'd1;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                illegal_q <= !cmd.legal;
                if (go) begin
                    run_q   <= 1'b1;
                    way_q   <= 2'd0;
                    elem_q  <= '0;
                    ways_q  <= cmd.ways;
                    unzip_q <= cmd.unzip;
                    vlast_q <= vl - 1'b1;
                    lin_q   <= IDX_W'(cmd.lin_base);
                    step_q  <= {1'b0, subvl_m1} + 3'd1;
                end else begin
                    done_q <= 1'b1;
                end
            end else if (run_q) begin
                lin_q <= lin_q + IDX_W'(step_q);
                if (last_way) begin
                    way_q  <= 2'd0;
                    elem_q <= elem_q + 1'b1;
                    if (last_elem) begin
                        run_q  <= 1'b0;
                        done_q <= 1'b1;
                    end
                end else begin
                    way_q <= way_q + 2'd1;
                end
            end
        end
    end

    // One per-slot pointer register, stepped once per completed element.
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        logic [IDX_W-1:0] ptr_r;
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_r <= '0;
            else if (go)
                ptr_r <= IDX_W'(slot_base[k]);
            else if (elem_adv)
                ptr_r <= ptr_r + IDX_W'(step_q);
        end
        assign ptr_all[k] = ptr_r;
    end

    // Select the active slot: a one-way run always uses the middle slot.
    always_comb begin
        cur_slot = (ways_q == 2'd1) ? 2'd1 : way_q;
        case (cur_slot)
            2'd0:    slot_ptr = ptr_all[0];
            2'd1:    slot_ptr = ptr_all[1];
            default: slot_ptr = ptr_all[2];
        endcase
    end

    assign wr_en     = run_q;
    assign src_idx   = unzip_q ? lin_q : slot_ptr;
    assign dst_idx   = unzip_q ? slot_ptr : lin_q;
    assign done      = done_q;
    assign illegal   = illegal_q;
    assign run_unzip = unzip_q;
    assign run_step  = step_q;
endmodule

// File: rtl/regzip_sequencer.sv
// Top level of the zip/unzip sequencer: decoder feeding the stepper.
// Assumes the register file consumes one transfer per strobe, no stall.
module regzip_sequencer
    import regzip_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int VL_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic [VL_W-1:0]   vl,
    input  logic [1:0]        subvl_m1,
    output logic              wr_en,
    output logic [IDX_W-1:0]  src_idx,
    output logic [IDX_W-1:0]  dst_idx,
    output logic              done,
    output logic              illegal
);
    regzip_cmd_t cmd;
    logic        run_unzip;
    logic [2:0]  run_step;

    regzip_decode u_dec (
        .instr (instr),
        .cmd   (cmd)
    );

    regzip_stepper #(.IDX_W(IDX_W), .VL_W(VL_W)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd       (cmd),
        .vl        (vl),
        .subvl_m1  (subvl_m1),
        .wr_en     (wr_en),
        .src_idx   (src_idx),
        .dst_idx   (dst_idx),
        .done      (done),
        .illegal   (illegal),
        .run_unzip (run_unzip),
        .run_step  (run_step)
    );
endmodule

// File: rtl/regzip_sequencer_chk.sv
// Protocol checker for the sequencer, attached by bind. Watches the strobe,
// index and completion ports against the latched run mode and step size.
module regzip_sequencer_chk #(
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             wr_en,
    input logic [IDX_W-1:0] src_idx,
    input logic [IDX_W-1:0] dst_idx,
    input logic             done,
    input logic             illegal,
    input logic             run_unzip,
    input logic [2:0]       run_step
);
    // R4
    zip_dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && !run_unzip) |-> dst_idx == $past(dst_idx) + IDX_W'(run_step));

    // R8
    unzip_src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && run_unzip) |-> src_idx == $past(src_idx) + IDX_W'(run_step));

    // R2
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_en);

    // R9
    strobe_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> $past(start));

    // R9
    done_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en);

    // R9
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) || $past(start)));
endmodule

bind regzip_sequencer regzip_sequencer_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wr_en     (wr_en),
    .src_idx   (src_idx),
    .dst_idx   (dst_idx),
    .done      (done),
    .illegal   (illegal),
    .run_unzip (run_unzip),
    .run_step  (run_step)
);

// File: tb/regzip_sequencer_test.sv
`timescale 1ns/1ps
// Scoreboard bench: run_op predicts each transfer into queues, the monitor
// pops and compares on every strobe, run_op then checks done timing.
module regzip_sequencer_test;
    localparam int IDX_W = 7;
    localparam int VL_W  = 7;
    localparam int MASK  = (1 << IDX_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [31:0]       instr = '0;
    logic [VL_W-1:0]   vl = '0;
    logic [1:0]        subvl_m1 = '0;
    logic              wr_en, done, illegal;
    logic [IDX_W-1:0]  src_idx, dst_idx;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    q_src[$];
    int    q_dst[$];
    string q_req[$];

    regzip_sequencer #(.IDX_W(IDX_W), .VL_W(VL_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .vl(vl),
        .subvl_m1(subvl_m1), .wr_en(wr_en), .src_idx(src_idx),
        .dst_idx(dst_idx), .done(done), .illegal(illegal)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int xo, input int t, input int c,
                                       input int b, input int a, input int rcb);
        return {6'd19, 5'(t), 5'(c), 5'(b), 5'(a), 5'(xo), 1'(rcb)};
    endfunction

    // Monitor: every strobe must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (q_src.size() == 0) begin
                chk(1'b0, "R9 unexpected strobe", int'(dst_idx), -1);
            end else begin
                automatic int    es = q_src.pop_front();
                automatic int    ed = q_dst.pop_front();
                automatic string er = q_req.pop_front();
                chk(int'(src_idx) == es, {er, " src"}, int'(src_idx), es);
                chk(int'(dst_idx) == ed, {er, " dst"}, int'(dst_idx), ed);
            end
        end
    end

    // Driver: predict transfers, start the op, check done timing and leftovers.
    task automatic run_op(input logic [31:0] ins, input int vl_i, input int s,
                          input string req, input bit poke);
        int op, t, c, b, a, xo, w, n, k;
        bit legal, unz;
        int slots[3];
        int lin;
        op = int'(ins[31:26]); t = int'(ins[25:21]); c = int'(ins[20:16]);
        b  = int'(ins[15:11]); a = int'(ins[10:6]);  xo = int'(ins[5:1]);
        legal = (op == 19) && (xo == 10 || xo == 11);
        unz   = (xo == 11);
        w = (b == 0) ? 1 : ((a == 0) ? 2 : 3);
        lin = unz ? c : t;
        slots[0] = b; slots[1] = unz ? t : c; slots[2] = a;
        n = legal ? vl_i * w : 0;
        if (legal) begin
            for (int i = 0; i < vl_i; i++) begin
                for (int j = 0; j < w; j++) begin
                    automatic int sl  = (w == 1) ? 1 : j;
                    automatic int lv  = (lin + (i * w + j) * s) & MASK;
                    automatic int pv  = (slots[sl] + i * s) & MASK;
                    q_src.push_back(unz ? lv : pv);
                    q_dst.push_back(unz ? pv : lv);
                    q_req.push_back(req);
                end
            end
        end
        @(negedge clk);
        instr = ins; vl = VL_W'(vl_i); subvl_m1 = 2'(s - 1); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (!done && k < 2000) begin
            @(negedge clk);
            k++;
            if (poke && k == 2) begin
                instr = mk(10, 1, 2, 3, 4, 0); vl = 7'd9; start = 1'b1;
            end
            if (poke && k == 3) start = 1'b0;
        end
        chk(k == n + 1, {req, " R9 done cycle"}, k, n + 1);
        chk(q_src.size() == 0, {req, " R9 missing strobes"}, q_src.size(), 0);
        chk(illegal == !legal, {req, " R2 illegal flag"}, int'(illegal), int'(!legal));
        q_src.delete(); q_dst.delete(); q_req.delete();
        @(negedge clk);
        chk(done == 1'b0, {req, " R9 done one cycle"}, int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(wr_en == 1'b0, "R11 wr_en", int'(wr_en), 0);
        chk(done == 1'b0, "R11 done", int'(done), 0);
        chk(illegal == 1'b0, "R11 illegal", int'(illegal), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(mk(10, 8, 20, 0, 0, 0), 4, 1, "R3 zip copy", 0);
        run_op(mk(10, 40, 5, 12, 0, 0), 3, 1, "R4 zip two-way", 0);
        run_op(mk(10, 60, 3, 7, 30, 0), 3, 1, "R5 zip three-way", 0);
        run_op(mk(10, 2, 9, 0, 17, 0), 3, 1, "R6 A ignored", 0);
        run_op(mk(10, 10, 1, 2, 3, 0), 2, 3, "R7 subvl3 three-way", 0);
        run_op(mk(10, 30, 6, 14, 0, 0), 20, 4, "R7 subvl4 wrap", 0);
        run_op(mk(11, 4, 16, 0, 0, 0), 3, 2, "R8 unzip one-way", 0);
        run_op(mk(11, 9, 20, 25, 0, 0), 3, 1, "R8 unzip two-way", 0);
        run_op(mk(11, 9, 31, 25, 19, 0), 4, 2, "R8 unzip three-way", 0);
        run_op({6'd18, 26'h0_4000_14}, 3, 1, "R1 bad opcode", 0);
        run_op(mk(10, 1, 2, 3, 4, 0), 2, 1, "R2 clears illegal", 0);
        run_op(mk(12, 1, 2, 3, 4, 0), 2, 1, "R1 bad xo", 0);
        run_op(mk(11, 1, 2, 0, 0, 0), 0, 1, "R9 zero length", 0);
        run_op(mk(10, 50, 3, 7, 30, 0), 4, 1, "R10 start mid-run", 1);
        run_op(mk(10, 40, 5, 12, 0, 1), 3, 1, "R10 record bit", 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule